// File: doc/BRIEF.md
# Tiled QKV Projection Engine

This block forms the query, key and value matrices of one attention head. The embedding axis is walked in slices of `TS` elements. For each slice the host fills an on-chip input tile and three weight tiles through a single valid/ready load port, then starts that pass. The engine multiplies the input tile by all three weight tiles at once and adds the partial products onto the sums kept from earlier passes. All data is 8-bit signed fixed point, and the sums are 32-bit signed.

The number of passes is the runtime embedding length divided by `TS`. The three bias vectors enter small registers through the same port, and they may still arrive while a pass is computing. Biases are applied once, after the last pass. Then `done` pulses, and the three result buffers (`SEQ` rows by `HD` columns each) can be read combinationally by selector, row and column.

Top module: `qkv_tile_proj`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, and `ld_ready` is 0 for every `ld_sel` value.
- R2: A `start` whose `emb_dim` is zero or not a multiple of `TS` pulses `err` high for exactly one cycle, on the cycle after `start`. The block stays idle and `busy` stays 0.
- R3: After `done`, Q/K/V element (s, j) equals the sum over all embedding positions e of X[s][e]·W[e][j], plus bias[j]. Every term is signed 8-bit. The sum is held as a 32-bit signed value and does not wrap, even with 768 products of -128 by -128.
- R4: A valid job runs exactly `emb_dim`/`TS` passes. After each pass except the last, the block returns to accepting tile data. `done` stays 0 until the last pass has finished.
- R5: Tile data (`ld_sel` 0 to 3) is accepted only while the block waits for a tile. During computation `ld_ready` is 0 for these selectors.
- R6: Bias registers are cleared by every accepted `start`. A job that loads no bias returns the plain sums.
- R7: A bias written while the last pass is computing is included in the result.
- R8: `done` is a one-cycle pulse. `busy` falls in the same cycle, and all three result buffers already hold their final values when `done` is high.
- R9: Encodings: `ld_sel` 0 selects the input tile at address s·TS+k. `ld_sel` 1, 2 and 3 select the Q, K and V weight tiles at address k·HD+j. `ld_sel` 4, 5 and 6 select the Q, K and V biases at address j. `rd_sel` 0, 1 and 2 read Q, K and V.
- R10: A `start` while `busy` is high is ignored. It raises no `err`, and the running job's results are unchanged.
- R11: While idle, the result buffers hold their values. A load attempt while `ld_ready` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (only while idle) |
| emb_dim | input | EW | Embedding length for the job |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat accepted this cycle |
| ld_sel | input | 3 | Load target selector (see R9) |
| ld_addr | input | LA | Element address inside the target |
| ld_data | input | DW | Signed element value |
| tile_go | input | 1 | Current tile is loaded; compute this pass |
| rd_sel | input | 2 | Result buffer selector |
| rd_row | input | RW | Result row (sequence position) |
| rd_col | input | CW | Result column (head dimension) |
| rd_data | output | AW | Selected result element |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle bad-length pulse |

## Verification
The bench builds the engine with three rows, a tile of four and a head width of two. The non-square shape exposes any swap of row and column index in the tile addressing and in the result layout. With these values one pass lasts exactly six cycles, so six bias writes issued right after `tile_go` all fall inside the compute window of the last pass. An embedding length of 768 gives 192 passes and fills the accumulator with the largest possible magnitude. Lengths 4 to 64 cover both single-pass and multi-pass jobs.

// File: rtl/qkv_tile_proj.sv
module qkv_tile_proj #(
  parameter int SEQ = 4,
  parameter int TS  = 4,
  parameter int HD  = 4,
  parameter int DW  = 8,
  parameter int AW  = 32,
  parameter int EW  = 10,
  localparam int XN  = SEQ * TS,
  localparam int WN  = TS * HD,
  localparam int RN  = SEQ * HD,
  localparam int LA  = (XN > WN) ? $clog2(XN) : $clog2(WN),
  localparam int RW  = (SEQ > 1) ? $clog2(SEQ) : 1,
  localparam int CW  = (HD > 1) ? $clog2(HD) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [EW-1:0]        emb_dim,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [2:0]           ld_sel,
  input  logic [LA-1:0]        ld_addr,
  input  logic signed [DW-1:0] ld_data,
  input  logic                 tile_go,
  input  logic [1:0]           rd_sel,
  input  logic [RW-1:0]        rd_row,
  input  logic [CW-1:0]        rd_col,
  output logic signed [AW-1:0] rd_data,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);
  localparam int XIW = (XN > 1) ? $clog2(XN) : 1;
  localparam int WIW = (WN > 1) ? $clog2(WN) : 1;
  localparam int RIW = (RN > 1) ? $clog2(RN) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_CALC, S_BIAS} st_t;
  st_t st;

  logic signed [DW-1:0] x_mem [XN];
  logic signed [DW-1:0] w_mem [3][WN];
  logic signed [DW-1:0] b_reg [3][HD];
  logic signed [AW-1:0] acc   [3][RN];
  logic signed [AW-1:0] dot   [3];

  logic [EW-1:0] npass, pass_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  wire len_ok   = (emb_dim % TS == 0) && (emb_dim != '0);
  wire go_ok    = (st == S_IDLE) && start && len_ok;
  wire wr       = ld_valid && ld_ready;
  wire last_pos = (row_q == RW'(SEQ - 1)) && (col_q == CW'(HD - 1));
  wire [RIW-1:0] cur_idx = RIW'(row_q * HD + col_q);
  wire [RIW-1:0] rd_idx  = RIW'(rd_row * HD + rd_col);

  assign busy     = (st != S_IDLE);
  assign ld_ready = (st == S_LOAD) || ((st == S_CALC) && ld_sel[2] && ld_sel != 3'd7);
  assign rd_data  = (rd_sel == 2'd3) ? '0 : acc[rd_sel][rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      err <= 1'b0;
      npass <= '0;
      pass_q <= '0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (len_ok) begin
            npass <= EW'(emb_dim / TS);
            pass_q <= '0;
            st <= S_LOAD;
          end else err <= 1'b1;
        end
        S_LOAD: if (tile_go) begin
          st <= S_CALC;
          row_q <= '0;
          col_q <= '0;
        end
        S_CALC: begin
          if (col_q == CW'(HD - 1)) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
          end else col_q <= col_q + 1'b1;
          if (last_pos) begin
            row_q <= '0;
            if (pass_q == npass - EW'(1)) st <= S_BIAS;
            else begin
              pass_q <= pass_q + 1'b1;
              st <= S_LOAD;
            end
          end
        end
        default: begin
          st <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !ld_sel[2]) begin
      if (ld_sel[1:0] == 2'd0) x_mem[XIW'(ld_addr)] <= ld_data;
      else w_mem[ld_sel[1:0] - 2'd1][WIW'(ld_addr)] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || go_ok) begin
      for (int m = 0; m < 3; m++)
        for (int j = 0; j < HD; j++) b_reg[m][j] <= '0;
    end else if (wr && ld_sel[2]) begin
      b_reg[ld_sel[1:0]][CW'(ld_addr)] <= ld_data;
    end
  end

  always_comb begin
    for (int m = 0; m < 3; m++) begin
      logic signed [2*DW-1:0] p;
      dot[m] = '0;
      for (int k = 0; k < TS; k++) begin
        p = x_mem[XIW'(row_q * TS + k)] * w_mem[m][WIW'(k * HD + col_q)];
        dot[m] = dot[m] + p;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < 3; m++)
        for (int i = 0; i < RN; i++) acc[m][i] <= '0;
    end else if (st == S_CALC) begin
      for (int m = 0; m < 3; m++)
        acc[m][cur_idx] <= ((pass_q == '0) ? '0 : acc[m][cur_idx]) + dot[m];
    end else if (st == S_BIAS) begin
      for (int m = 0; m < 3; m++)
        for (int i = 0; i < RN; i++) acc[m][i] <= acc[m][i] + b_reg[m][i % HD];
    end
  end

  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  p_pass_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CALC) |-> (pass_q < npass));
  p_tile_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CALC && !ld_sel[2]) |-> !ld_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st == S_IDLE)) |-> $stable(acc[0][0]));
endmodule

// File: tb/test_qkv_tile_proj.sv
module test_qkv_tile_proj;
  localparam int SEQ = 3, TS = 4, HD = 2, DW = 8, AW = 32, EW = 10;
  localparam int LA = 4, RW = 2, CW = 1, EMAX = 768;

  logic clk = 0, rst_n = 0, start = 0, ld_valid = 0, tile_go = 0;
  logic [EW-1:0] emb_dim = '0;
  logic [2:0] ld_sel = '0;
  logic [LA-1:0] ld_addr = '0;
  logic signed [DW-1:0] ld_data = '0;
  logic [1:0] rd_sel = '0;
  logic [RW-1:0] rd_row = '0;
  logic [CW-1:0] rd_col = '0;
  logic signed [AW-1:0] rd_data;
  logic ld_ready, busy, done, err;

  int checks = 0, errors = 0;
  int xm [SEQ][EMAX];
  int wm [3][EMAX][HD];
  int bm [3][HD];

  always #10 clk = ~clk;

  qkv_tile_proj #(.SEQ(SEQ), .TS(TS), .HD(HD), .DW(DW), .AW(AW), .EW(EW)) i_qkv_tile_proj (
    .clk(clk), .rst_n(rst_n), .start(start), .emb_dim(emb_dim),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .tile_go(tile_go), .rd_sel(rd_sel), .rd_row(rd_row),
    .rd_col(rd_col), .rd_data(rd_data), .busy(busy), .done(done), .err(err));

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd8();
    return int'($signed(8'($urandom)));
  endfunction

  function automatic int expv(int m, int s, int j, int emb);
    int sum = 0;
    for (int e = 0; e < emb; e++) sum += xm[s][e] * wm[m][e][j];
    return sum + bm[m][j];
  endfunction

  task automatic ld(int sel, int addr, int val, string req);
    ld_valid = 1; ld_sel = 3'(sel); ld_addr = LA'(addr); ld_data = DW'(val);
    #1 chk(ld_ready == 1'b1, req, ld_ready, 1);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic check_results(int emb, string req);
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < SEQ; s++)
        for (int j = 0; j < HD; j++) begin
          rd_sel = 2'(m); rd_row = RW'(s); rd_col = CW'(j);
          #1 chk(rd_data == expv(m, s, j, emb), req, rd_data, expv(m, s, j, emb));
        end
  endtask

  task automatic run_job(int emb, bit use_bias, bit extreme, bit late, bit poke, string req);
    int np = emb / TS;
    int n;
    for (int s = 0; s < SEQ; s++)
      for (int e = 0; e < emb; e++) xm[s][e] = extreme ? -128 : rnd8();
    for (int m = 0; m < 3; m++) begin
      for (int e = 0; e < emb; e++)
        for (int j = 0; j < HD; j++) wm[m][e][j] = extreme ? -128 : rnd8();
      for (int j = 0; j < HD; j++) bm[m][j] = use_bias ? (extreme ? -128 : rnd8()) : 0;
    end
    start = 1; emb_dim = EW'(emb);
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1 && err == 1'b0, "R4 busy after start", busy, 1);
    for (int p = 0; p < np; p++) begin
      for (int s = 0; s < SEQ; s++)
        for (int k = 0; k < TS; k++) ld(0, s * TS + k, xm[s][p * TS + k], "R9 x load");
      if (poke && p == 0) begin
        start = 1; emb_dim = EW'(3);
        @(negedge clk);
        start = 0;
        chk(err == 1'b0 && busy == 1'b1, "R10 start while busy", err, 0);
      end
      for (int m = 0; m < 3; m++)
        for (int k = 0; k < TS; k++)
          for (int j = 0; j < HD; j++) ld(m + 1, k * HD + j, wm[m][p * TS + k][j], "R9 w load");
      if (p == 0 && use_bias && !late)
        for (int m = 0; m < 3; m++)
          for (int j = 0; j < HD; j++) ld(m + 4, j, bm[m][j], "R9 bias load");
      tile_go = 1;
      @(negedge clk);
      tile_go = 0;
      ld_sel = 3'd0;
      #1 chk(ld_ready == 1'b0, "R5 tile closed in compute", ld_ready, 0);
      if (p == np - 1 && late)
        for (int m = 0; m < 3; m++)
          for (int j = 0; j < HD; j++) ld(m + 4, j, bm[m][j], "R7 late bias");
      if (p != np - 1) begin
        n = 0;
        ld_sel = 3'd0;
        #1;
        while (!ld_ready && n < 50) begin @(negedge clk); #1; n++; end
        if (p == 0 || p == np - 2)
          chk(ld_ready == 1'b1 && done == 1'b0 && busy == 1'b1, "R4 next pass", ld_ready, 1);
      end
    end
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk(done == 1'b1 && busy == 1'b0, "R8 done with busy low", done, 1);
    check_results(emb, req);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      ld_sel = 3'(s);
      #1 chk(ld_ready == 1'b0, "R1 ld_ready reset", ld_ready, 0);
    end
    chk(busy == 0 && done == 0 && err == 0, "R1 reset outputs", {busy, done, err}, 0);

    start = 1; emb_dim = EW'(6);
    @(negedge clk);
    start = 0;
    chk(err == 1'b1 && busy == 1'b0, "R2 err on non-multiple", err, 1);
    @(negedge clk);
    chk(err == 1'b0 && busy == 1'b0, "R2 err one cycle", err, 0);
    start = 1; emb_dim = '0;
    @(negedge clk);
    start = 0;
    chk(err == 1'b1 && busy == 1'b0, "R2 err on zero", err, 1);
    @(negedge clk);

    run_job(4, 1, 0, 0, 0, "R3 single pass");
    run_job(16, 0, 0, 0, 1, "R6 bias cleared / R10");
    run_job(12, 1, 0, 1, 0, "R7 late bias result");
    run_job(768, 1, 1, 0, 0, "R3 no overflow 768");
    for (int t = 0; t < 5; t++)
      run_job(4 * (1 + int'($urandom_range(15))), 1, 0, t[0], 0, "R3 random job");

    for (int k = 0; k < 4; k++) begin
      ld_valid = 1; ld_sel = 3'(k); ld_addr = '0; ld_data = 8'sd99;
      @(negedge clk);
    end
    ld_valid = 0;
    repeat (3) @(negedge clk);
    check_results(emb_dim, "R11 hold while idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule